// File: doc/BRIEF.md
# Integer ALU with Status Flag Register

This block is a 32-bit integer arithmetic and logic unit. It takes two operands and a 3-bit operation code and produces a result in the same cycle. Add and subtract are supported, along with bitwise AND, OR and XOR. From each result it derives six status flags: unsigned carry/borrow, signed overflow, sign, zero, a nibble-boundary auxiliary carry and even parity over the low byte.

The flags are held in a 6-bit register. That register loads the newly computed flags on the rising clock edge when the update enable is high. When the enable is low it keeps its value. This lets a surrounding datapath compute a result without changing the flags. The register is cleared by an active-low reset.

The block has no state machine. Its only storage is the flag register, which has two conditions: LOAD when the enable is high and HOLD when it is low.

Top module: `alu_flags_top`

## Requirements
- R1: The result output is combinational. Operation code 0 gives a+b, 1 gives a-b, 2 gives a AND b, 3 gives a OR b, and 4 gives a XOR b, all modulo 2^32.
- R2: Operation codes 5, 6 and 7 give a result of zero. Their flag update follows the logical-operation rule.
- R3: The sign flag (flags bit 4) loads the top bit of the result.
- R4: The zero flag (flags bit 3) is set exactly when all 32 result bits are zero.
- R5: The carry flag (flags bit 0) loads the carry out of bit 31 for add. For subtract it loads the borrow, which is set when a < b unsigned.
- R6: The parity flag (flags bit 1) is set when result bits 7..0 hold an even number of ones.
- R7: When the update enable is low, the flag register does not change at the clock edge.
- R8: For codes 2 to 7, the carry flag, the overflow flag (bit 5) and the auxiliary flag (bit 2) are loaded as zero.
- R9: The overflow flag (flags bit 5) is set for add when both operands share a sign and the result's sign differs. For subtract it is set when the operands' signs differ and the result's sign differs from a.
- R10: The auxiliary flag (flags bit 2) is set for add when a[3:0]+b[3:0] exceeds 15. For subtract it is set when a[3:0] < b[3:0].
- R11: While reset is low, the flag register is cleared to all zeros on the clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the flag register |
| op_i | input | 3 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| flag_we_i | input | 1 | Flag register update enable |
| result_o | output | 32 | Combinational result |
| flags_o | output | 6 | Flag register {OF, SF, ZF, AF, PF, CF}, bit 5 down to bit 0 |

## Verification
A wrong result shows on result_o within the same cycle as the operands. A wrong flag value appears on flags_o one edge after an enabled update. Because the register holds its value, a bad flag stays visible through every following disabled cycle. A flag that changes while the enable is low is visible in the cycle right after that edge. The stimulus forces each flag to both values through boundary operands: 0x7FFFFFFF+1, 0xFFFFFFFF+1, 0-1 and 0x80000000-1.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4
    } alu_op_e;

    // bit 5 .. bit 0
    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic aux;
        logic par;
        logic cry;
    } alu_flags_t;

    localparam int FLAGS_W = $bits(alu_flags_t);

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W      = 32,
    parameter int NIB_B  = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cry,
    output logic         ovf,
    output logic         aux
);
    logic [W:0]   ext;
    logic [W-1:0] b_eff;
    logic [W-1:0] diff_bits;

    always_comb begin
        b_eff     = sub ? ~b : b;
        ext       = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum       = ext[W-1:0];
        // carry out normalised so that for subtract it reads as borrow
        cry       = ext[W] ^ sub;
        // carry (or borrow) entering bit NIB_B is recovered from the sum bit
        diff_bits = a ^ b ^ sum;
        aux       = diff_bits[NIB_B];
        if (sub)
            ovf = (a[W-1] != b[W-1]) && (sum[W-1] != a[W-1]);
        else
            ovf = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_flags_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    output logic [W-1:0]    res
);
    always_comb begin
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
    import alu_flags_pkg::*;
#(
    parameter int W     = 32,
    parameter int PAR_W = 8
) (
    input  logic [W-1:0] res,
    input  logic         arith,
    input  logic         cry_in,
    input  logic         ovf_in,
    input  logic         aux_in,
    output alu_flags_t   flags
);
    logic [PAR_W:0] par_chain;

    assign par_chain[0] = 1'b1;
    for (genvar i = 0; i < PAR_W; i++) begin : g_par
        assign par_chain[i+1] = par_chain[i] ^ res[i];
    end

    always_comb begin
        flags.sgn = res[W-1];
        flags.zro = (res == '0);
        flags.par = par_chain[PAR_W];
        flags.cry = arith & cry_in;
        flags.ovf = arith & ovf_in;
        flags.aux = arith & aux_in;
    end
endmodule

// File: rtl/alu_flags_top.sv
module alu_flags_top
    import alu_flags_pkg::*;
#(
    parameter int W     = 32,
    parameter int PAR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OP_W-1:0]    op_i,
    input  logic [W-1:0]       a_i,
    input  logic [W-1:0]       b_i,
    input  logic               flag_we_i,
    output logic [W-1:0]       result_o,
    output logic [FLAGS_W-1:0] flags_o
);
    logic [W-1:0] as_sum;
    logic [W-1:0] lg_res;
    logic         as_cry;
    logic         as_ovf;
    logic         as_aux;
    logic         is_arith;
    logic         is_sub;
    alu_flags_t   nxt_flags;
    alu_flags_t   flag_q;

    always_comb begin
        is_sub   = (op_i == OP_SUB);
        is_arith = (op_i == OP_ADD) || is_sub;
    end

    alu_addsub #(.W(W)) u_addsub (
        .a   (a_i),
        .b   (b_i),
        .sub (is_sub),
        .sum (as_sum),
        .cry (as_cry),
        .ovf (as_ovf),
        .aux (as_aux)
    );

    alu_logic #(.W(W)) u_logic (
        .op  (op_i),
        .a   (a_i),
        .b   (b_i),
        .res (lg_res)
    );

    assign result_o = is_arith ? as_sum : lg_res;

    alu_flag_gen #(.W(W), .PAR_W(PAR_W)) u_flags (
        .res    (result_o),
        .arith  (is_arith),
        .cry_in (as_cry),
        .ovf_in (as_ovf),
        .aux_in (as_aux),
        .flags  (nxt_flags)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= '0;
        else if (flag_we_i)
            flag_q <= nxt_flags;
    end

    assign flags_o = flag_q;
endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [2:0]   op_i,
    input logic         flag_we_i,
    input logic [W-1:0] result_o,
    input logic [5:0]   flags_o
);
    a_r11_reset_clear: assert property (@(posedge clk)
        !rst_n |=> flags_o == 6'd0);

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we_i |=> $stable(flags_o));

    a_r3_sign: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we_i |=> flags_o[4] == $past(result_o[W-1]));

    a_r4_zero: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we_i |=> flags_o[3] == ($past(result_o) == '0));

    a_r6_parity: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we_i |=> flags_o[1] == ~^($past(result_o[7:0])));

    a_r8_logic_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we_i && op_i >= 3'd2) |=> (flags_o[5] == 1'b0 && flags_o[2] == 1'b0 && flags_o[0] == 1'b0));

    a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        op_i >= 3'd5 |-> result_o == '0);
endmodule

bind alu_flags_top alu_flags_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_i      (op_i),
    .flag_we_i (flag_we_i),
    .result_o  (result_o),
    .flags_o   (flags_o)
);

// File: tb/alu_flags_top_bench.sv
`timescale 1ns/1ps
module alu_flags_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = '0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic        flag_we_i = 1'b0;
    logic [31:0] result_o;
    logic [5:0]  flags_o;

    int total = 0;
    int bad = 0;
    bit ended = 0;
    logic [5:0] ref_flags = '0;

    typedef struct {
        logic [5:0] flags;
        string      tag;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    alu_flags_top u_alu_flags_top (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
        .flag_we_i(flag_we_i), .result_o(result_o), .flags_o(flags_o)
    );

    // independent reference: {flags[5:0], result[31:0]}
    function automatic logic [37:0] model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] r;
        logic cf, of, af, sf, zf, pf;
        logic [32:0] wide;
        cf = 0; of = 0; af = 0;
        case (op)
            3'd0: begin
                wide = {1'b0, a} + {1'b0, b};
                r = wide[31:0];
                cf = wide[32];
                af = ({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15;
                of = (a[31] == b[31]) && (r[31] != a[31]);
            end
            3'd1: begin
                r = a - b;
                cf = a < b;
                af = a[3:0] < b[3:0];
                of = (a[31] != b[31]) && (r[31] != a[31]);
            end
            3'd2: r = a & b;
            3'd3: r = a | b;
            3'd4: r = a ^ b;
            default: r = 32'd0;
        endcase
        sf = r[31];
        zf = (r == 32'd0);
        pf = 1'b1;
        for (int i = 0; i < 8; i++) pf = pf ^ r[i];
        return {of, sf, zf, af, pf, cf, r};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: applies one operation at a falling edge and queues expected flags
    task automatic drive(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic we, input string tag);
        logic [37:0] m;
        exp_t e;
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; flag_we_i = we;
        m = model(op, a, b);
        #1;
        check({tag, " result"}, result_o, m[31:0]);
        if (we) ref_flags = m[37:32];
        e.flags = ref_flags;
        e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compares registered flags after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check({e.tag, " flags"}, {26'd0, flags_o}, {26'd0, e.flags});
            end
        end
    end

    initial begin
        #200000;
        if (!ended) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        flag_we_i = 1'b1;
        op_i = 3'd1; a_i = 0; b_i = 1;
        repeat (3) @(posedge clk);
        #2;
        check("R11 reset flags", {26'd0, flags_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        drive(3'd0, 32'h7FFF_FFFF, 32'h1, 1, "R9 R10 add signed overflow");
        drive(3'd0, 32'hFFFF_FFFF, 32'h1, 1, "R5 R4 add carry to zero");
        drive(3'd0, 32'h0000_0003, 32'h4, 1, "R1 R6 add small");
        drive(3'd1, 32'h0, 32'h1, 1, "R5 R10 sub borrow");
        drive(3'd1, 32'h8000_0000, 32'h1, 1, "R9 sub signed overflow");
        drive(3'd1, 32'h1234_5678, 32'h1234_5678, 1, "R4 sub equal");
        drive(3'd0, 32'h5, 32'h6, 1, "R3 add sign clear");
        drive(3'd2, 32'hF0F0_FF00, 32'hFF00_F0F0, 1, "R8 and");
        drive(3'd1, 32'h0, 32'h1, 1, "R5 set before logic");
        drive(3'd3, 32'h8000_0000, 32'h0000_0007, 1, "R8 R3 or clears carry");
        drive(3'd4, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 1, "R8 R4 xor zero");
        drive(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, "R5 add big");
        drive(3'd4, 32'h0, 32'h1, 0, "R7 hold xor");
        drive(3'd1, 32'h0, 32'h0, 0, "R7 hold sub");
        for (int c = 5; c < 8; c++) begin
            drive(3'd1, 32'h0, 32'h1, 1, "R2 prime");
            drive(c[2:0], 32'hDEAD_BEEF, 32'h1234_5678, 1, "R2 unused code");
        end
        drive(3'd0, 32'h0000_0008, 32'h0000_0008, 1, "R10 add nibble carry");
        drive(3'd1, 32'h0000_0010, 32'h0000_0001, 1, "R10 sub nibble borrow");
        for (int i = 0; i < 300; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom; rb = $urandom;
            if (i % 7 == 0) rb = ra;
            drive(3'($urandom_range(0, 7)), ra, rb, 1'($urandom_range(0, 1)), "R1 R7 random");
        end
        @(negedge clk);
        flag_we_i = 1'b0;
        repeat (3) @(posedge clk);
        #3;
        ended = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule